// File: doc/BRIEF.md
# Three-Pixel Gray Byte Packer

This block turns a raster stream of 8-bit grayscale pixels into the byte layout that a monochrome-gray panel memory accepts, where each byte carries three pixels. Each pixel is cut down to a four-level value, and each level is turned into a 3-bit drive code. The codes of the first two pixels of a group take three bits each. The third pixel keeps only the two upper bits of its code. The input and output both use ready/valid handshakes. The upstream marks the first pixel of each row and the last pixel of each row, so grouping starts again at every row.

A row must hold a multiple of three pixels. If a row closes part way through a group, or a new row starts while a group is still open, the block discards the unfinished byte and raises an error pulse. While the output byte is held back by the sink, the input is stalled.

Top module: `gray3_packer`

## Requirements
- R1: Only the two most significant bits of a pixel (bits [7:6]) decide its level. The six lower bits have no effect on the output byte.
- R2: Each level maps to a 3-bit drive code: level 0 gives 3'b111, level 1 gives 3'b100, level 2 gives 3'b010, and level 3 gives 3'b000.
- R3: Within a group, the code of the first accepted pixel occupies out_byte[7:5] and the code of the second occupies out_byte[4:2].
- R4: The third pixel's code is shifted right by one and placed in out_byte[1:0]. Its least significant code bit is lost.
- R5: One byte is produced for every three accepted pixels. out_valid rises in the cycle after the third pixel is accepted, and never without such an acceptance.
- R6: A pixel accepted with in_sol high is always the first pixel of a new group. If an unfinished group was open at that moment, it is dropped and err pulses for one cycle.
- R7: A pixel accepted with in_eol high that is not the third of its group produces no byte. err pulses for one cycle and the group count returns to zero.
- R8: When the third pixel of a group is accepted with in_eol high, its byte is presented with out_eol high. Otherwise out_eol is low with the byte.
- R9: While out_valid is high and out_ready is low, out_valid, out_byte and out_eol hold steady and in_ready is low.
- R10: After reset, out_valid and err are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 8 | Grayscale pixel, 0 = black |
| in_sol | input | 1 | Pixel is the first of a row |
| in_eol | input | 1 | Pixel is the last of a row |
| out_valid | output | 1 | Packed byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_byte | output | 8 | Three packed pixel codes |
| out_eol | output | 1 | Byte ends a row |
| err | output | 1 | One-cycle pulse on a broken group |

## Verification
The bench sweeps all 64 combinations of three levels, with a different pattern in the low bits of each pixel. A wrong lookup, a swapped field, or a third code that keeps its low bit instead of its high bits would show up as a wrong byte in that sweep. Rows that end after one or two pixels, and row starts that arrive mid-group, test the discard path. A design that kept the stale partial byte would corrupt the next good group, and one that skipped the error would leave the err count short. Holding out_ready low tests the stall: a design that let the byte change or kept in_ready high would be caught while the byte waits.

// File: rtl/gray3_packer.sv
module gray3_packer #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_sol,
  input  logic             in_eol,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_eol,
  output logic             err
);
  localparam int LVL_MSB = PIX_W - 1;

  logic [1:0] cnt;
  logic [5:0] acc;
  logic [1:0] slot;
  logic [1:0] lvl;
  logic [2:0] code;
  logic       take;
  logic       broken;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;
  assign slot     = in_sol ? 2'd0 : cnt;
  assign lvl      = in_pix[LVL_MSB -: 2];
  assign broken   = (in_sol && cnt != 2'd0) || (in_eol && slot != 2'd2);

  always_comb begin
    case (lvl)
      2'd0:    code = 3'b111;
      2'd1:    code = 3'b100;
      2'd2:    code = 3'b010;
      default: code = 3'b000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= 2'd0;
      acc       <= 6'd0;
      out_valid <= 1'b0;
      out_byte  <= 8'd0;
      out_eol   <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (take) begin
        err <= broken;
        case (slot)
          2'd0: acc <= {code, 3'b000};
          2'd1: acc <= {acc[5:3], code};
          default: begin
            out_byte  <= {acc, code[2:1]};
            out_valid <= 1'b1;
            out_eol   <= in_eol;
          end
        endcase
        if (in_eol || slot == 2'd2) cnt <= 2'd0;
        else                        cnt <= slot + 2'd1;
      end
    end
  end
endmodule

// File: rtl/gray3_packer_chk.sv
module gray3_packer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sol,
  input logic       in_eol,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_eol,
  input logic       err
);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_eol)));

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_byte[7:5] == 3'b111 || out_byte[7:5] == 3'b100 ||
                    out_byte[7:5] == 3'b010 || out_byte[7:5] == 3'b000) &&
                   (out_byte[4:2] == 3'b111 || out_byte[4:2] == 3'b100 ||
                    out_byte[4:2] == 3'b010 || out_byte[4:2] == 3'b000)));

  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_ready && (in_eol || in_sol)));

  p_byte_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind gray3_packer gray3_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .out_eol(out_eol), .err(err)
);

// File: tb/gray3_packer_test.sv
module gray3_packer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_pix = 8'd0;
  logic       in_sol = 1'b0;
  logic       in_eol = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_byte;
  logic       out_eol;
  logic       err;

  int checks = 0;
  int fails = 0;
  int errs = 0;
  int cycles = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;

  gray3_packer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .out_eol(out_eol), .err(err)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) got_q.push_back({out_eol, out_byte});
    if (rst_n && err) errs++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [2:0] ref_code(int l);
    return {l < 2, (l == 0) || (l == 2), l == 0};
  endfunction

  function automatic logic [7:0] ref_byte(int a, int b, int c);
    logic [2:0] cc = ref_code(c);
    return {ref_code(a), ref_code(b), cc[2:1]};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] p, bit s, bit e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_pix = p; in_sol = s; in_eol = e;
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic drain(string req);
    repeat (3) @(negedge clk);
    check(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    while (got_q.size() > 0 && exp_q.size() > 0) begin
      logic [8:0] g = got_q.pop_front();
      logic [8:0] x = exp_q.pop_front();
      check(g == x, req, g, x);
    end
    got_q.delete(); exp_q.delete();
  endtask

  initial begin
    int e0;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(err == 1'b0, "R10 err", err, 0);
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    @(posedge clk); #1 out_ready = 1'b1;

    for (int i = 0; i < 64; i++) begin
      int a = i / 16, b = (i / 4) % 4, c = i % 4;
      send(8'((a << 6) | ((i * 37) & 63)), 1'b1, 1'b0);
      send(8'((b << 6) | ((i * 11 + 5) & 63)), 1'b0, 1'b0);
      send(8'((c << 6) | ((i * 23 + 9) & 63)), 1'b0, 1'b1);
      exp_q.push_back({1'b1, ref_byte(a, b, c)});
    end
    drain("R1 R2 R3 R4 R5 sweep");
    check(errs == 0, "R5 no err in clean rows", errs, 0);

    send(8'h00, 1'b1, 1'b0); send(8'h7f, 1'b0, 1'b0); send(8'hbf, 1'b0, 1'b0);
    send(8'hff, 1'b0, 1'b0); send(8'h40, 1'b0, 1'b0); send(8'h80, 1'b0, 1'b1);
    exp_q.push_back({1'b0, ref_byte(0, 1, 2)});
    exp_q.push_back({1'b1, ref_byte(3, 1, 2)});
    drain("R8 two-byte row");

    e0 = errs;
    send(8'h00, 1'b1, 1'b0); send(8'h00, 1'b0, 1'b1);
    send(8'h00, 1'b1, 1'b1);
    send(8'hc0, 1'b1, 1'b0); send(8'hc0, 1'b0, 1'b0); send(8'h40, 1'b0, 1'b1);
    exp_q.push_back({1'b1, ref_byte(3, 3, 1)});
    drain("R7 partial row dropped");
    check(errs - e0 == 2, "R7 err pulses", errs - e0, 2);

    e0 = errs;
    send(8'h00, 1'b1, 1'b0); send(8'h00, 1'b0, 1'b0);
    send(8'h80, 1'b1, 1'b0); send(8'h40, 1'b0, 1'b0); send(8'hc0, 1'b0, 1'b1);
    exp_q.push_back({1'b1, ref_byte(2, 1, 3)});
    drain("R6 restart on row start");
    check(errs - e0 == 1, "R6 err pulse", errs - e0, 1);

    @(posedge clk); #1 out_ready = 1'b0;
    send(8'h40, 1'b1, 1'b0); send(8'h00, 1'b0, 1'b0); send(8'hff, 1'b0, 1'b1);
    check(out_valid == 1'b1, "R5 byte after third pixel", out_valid, 1);
    held = out_byte;
    check(held == ref_byte(1, 0, 3), "R9 held value", held, ref_byte(1, 0, 3));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && out_byte == held && out_eol, "R9 byte held", out_byte, held);
      check(in_ready == 1'b0, "R9 input stalled", in_ready, 0);
    end
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R9 released", out_valid, 0);
    check(got_q.size() == 1, "R9 single delivery", got_q.size(), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule